// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block carries out interrupt entry for a small 8-bit controller core. It watches one non-maskable request line and eight maskable request lines. A rising edge on any line sets a pending latch. That latch stays set until its own entry takes place, no matter what the line does afterwards.

When the core marks an instruction boundary and the sequencer is idle, the block picks one pending request. The non-maskable request always wins. A maskable request is eligible only while the mask flag in the core's condition-code byte is clear, and the maskable requests follow a fixed order. The block captures the register values the core presents and pushes them through a byte-wide stack write port. It then reads a 16-bit vector through a read port with one cycle of latency. Last, it returns the new program counter, the new stack pointer and the condition codes with the mask flag set, and pulses an acknowledge that names the serviced source.

A parameter selects a reduced build. In that build only maskable line 0 counts, and it uses a single vector at 0xFFFA.

Top module: `irq_entry_seq`

## Requirements
- R1: A one-cycle pulse on a request line sets its pending latch. The request is still serviced at a later instruction boundary, even though the line has already returned low.
- R2: A pending non-maskable request (source id 8) is taken before any maskable one, even when condition-code bit 3 (the mask flag) is set. Its vector high byte is read from 0x1FFC and its low byte from 0x1FFD.
- R3: While condition-code bit 3 is set, a pending maskable request starts no entry: busy stays low. The request stays pending and is taken once the bit is clear.
- R4: Maskable line i carries source id i. Lines 0 to 7 rank from highest to lowest priority, and their vector bases are 0x1FF8, 0x1FEC, 0x1FEA, 0x1FF6, 0x1FF4, 0x1FF2, 0x1FF0 and 0x1FEE, respectively.
- R5: An entry makes exactly five stack writes on consecutive cycles. With captured stack pointer S, it writes the program counter low byte to S, the program counter high byte to S-1, X to S-2, the accumulator to S-3 and the condition codes to S-4. The returned stack pointer is S-5.
- R6: The condition codes returned with the new program counter equal the captured value with bit 3 set.
- R7: An entry clears only the latch it services. Other pending requests are taken by later entries in priority order.
- R8: An entry starts only in a cycle where the instruction-boundary input is high. Busy then stays high for exactly 11 consecutive cycles.
- R9: The vector is read high byte at the base address, then low byte at base+1. The new program counter {high, low} is valid for one cycle, in the last busy cycle, together with a one-cycle acknowledge that carries the source id.
- R10: Reset clears all pending latches and leaves the block idle. A request that rises while an entry is in progress is latched and is taken at a later boundary.
- R11: In the reduced build, only maskable line 0 is serviced, with its vector at 0xFFFA and 0xFFFB. The non-maskable line starts no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_line | input | 1 | Non-maskable request line |
| irq_lines | input | 8 | Maskable request lines, bit 0 highest priority |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| pc_in | input | 16 | Program counter to stack |
| x_in | input | 8 | Index register to stack |
| a_in | input | 8 | Accumulator to stack |
| cc_in | input | 8 | Condition codes; bit 3 is the mask flag |
| sp_in | input | 16 | Stack pointer at entry |
| vec_rdata | input | 8 | Vector read data, one cycle after the read strobe |
| busy | output | 1 | Entry in progress; the core is held |
| mem_we | output | 1 | Stack write strobe |
| mem_waddr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| vec_re | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| new_pc | output | 16 | Vector loaded as the new program counter |
| new_pc_valid | output | 1 | One-cycle strobe for new_pc, new_sp and new_cc |
| new_cc | output | 8 | Condition codes with the mask flag set |
| new_sp | output | 16 | Stack pointer after stacking |
| ack | output | 1 | One-cycle acknowledge of the serviced request |
| ack_src | output | 4 | Serviced source id (0 to 7 maskable, 8 non-maskable) |

## Verification
The hardest situation to reach from the ports is several latches pending at once after their lines have already fallen. The block must then drain them one entry at a time, in the fixed order, without losing any. The bench gets there by pulsing every pair of maskable lines, and the non-maskable line together with each maskable line, before a single boundary. It then issues one boundary per expected entry and checks the source id and vector each time. A request that rises in the middle of a running entry is produced by pulsing a line while busy is high, and the bench then checks that a later boundary picks it up.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   localparam int DW        = 8;
   localparam int AW        = 16;
   localparam int NUM_MASK  = 8;
   localparam int NUM_SRC   = NUM_MASK + 1;
   localparam int NMI_ID    = NUM_MASK;
   localparam int IDW       = 4;

   typedef logic [AW-1:0]  addr_t;
   typedef logic [DW-1:0]  byte_t;
   typedef logic [IDW-1:0] src_id_t;

   typedef enum logic [0:0] {ST_IDLE, ST_RUN} seq_state_t;

   localparam addr_t SINGLE_VEC = 16'hFFFA;

   // vector base per source id; order of maskable ids is priority order
   function automatic addr_t vec_base(input src_id_t id);
      case (id)
         4'd0:    vec_base = 16'h1FF8;
         4'd1:    vec_base = 16'h1FEC;
         4'd2:    vec_base = 16'h1FEA;
         4'd3:    vec_base = 16'h1FF6;
         4'd4:    vec_base = 16'h1FF4;
         4'd5:    vec_base = 16'h1FF2;
         4'd6:    vec_base = 16'h1FF0;
         4'd7:    vec_base = 16'h1FEE;
         4'd8:    vec_base = 16'h1FFC;
         default: vec_base = SINGLE_VEC;
      endcase
   endfunction
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
   #(parameter int N = 9)
   (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
   );

   logic [N-1:0] prev_q;
   logic [N-1:0] rise;

   assign rise = lines & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend   <= '0;
      end else begin
         prev_q <= lines;
         pend   <= (pend & ~clr) | rise;
      end
   end

   // a latched request survives until its own clear
   p_hold_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));

   // a rising line is never lost
   p_rise_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_entry_pkg::*;
   #(parameter bit FULL_SET = 1'b1)
   (
   input  logic [NUM_SRC-1:0] pend,
   input  logic               mask_set,
   output logic               grant_valid,
   output src_id_t            grant_id,
   output addr_t              grant_vec
   );

   generate
      if (FULL_SET) begin : g_full
         always_comb begin
            grant_valid = 1'b0;
            grant_id    = src_id_t'(0);
            if (pend[NMI_ID]) begin
               grant_valid = 1'b1;
               grant_id    = src_id_t'(NMI_ID);
            end else if (!mask_set) begin
               for (int i = NUM_MASK - 1; i >= 0; i--) begin
                  if (pend[i]) begin
                     grant_valid = 1'b1;
                     grant_id    = src_id_t'(i);
                  end
               end
            end
            grant_vec = vec_base(grant_id);
         end
      end else begin : g_single
         always_comb begin
            grant_valid = pend[0] && !mask_set;
            grant_id    = src_id_t'(0);
            grant_vec   = SINGLE_VEC;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
   import irq_entry_pkg::*;
   #(parameter int ENTRY_CYCLES = 11,
     parameter int MASK_BIT     = 3)
   (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  src_id_t start_id,
   input  addr_t   start_vec,
   input  addr_t   pc_in,
   input  byte_t   x_in,
   input  byte_t   a_in,
   input  byte_t   cc_in,
   input  addr_t   sp_in,
   input  byte_t   vec_rdata,
   output logic    busy,
   output logic    mem_we,
   output addr_t   mem_waddr,
   output byte_t   mem_wdata,
   output logic    vec_re,
   output addr_t   vec_addr,
   output addr_t   new_pc,
   output logic    new_pc_valid,
   output byte_t   new_cc,
   output addr_t   new_sp,
   output logic    ack,
   output src_id_t ack_src
   );

   localparam int SW = $clog2(ENTRY_CYCLES);
   localparam int PUSH_BYTES = 5;
   localparam logic [SW-1:0] LAST_STEP = SW'(ENTRY_CYCLES - 1);
   localparam logic [SW-1:0] PUSH_LAST = SW'(PUSH_BYTES - 1);
   localparam logic [SW-1:0] VHI_STEP  = SW'(PUSH_BYTES);
   localparam logic [SW-1:0] VLO_STEP  = SW'(PUSH_BYTES + 1);
   localparam byte_t MASK_ONE = byte_t'(1) << MASK_BIT;

   seq_state_t    st;
   logic [SW-1:0] step;
   addr_t         cap_pc, cap_sp, cap_vec;
   byte_t         cap_x, cap_a, cap_cc, vhi, vlo;
   src_id_t       cap_id;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         step    <= '0;
         cap_pc  <= '0;
         cap_sp  <= '0;
         cap_vec <= '0;
         cap_x   <= '0;
         cap_a   <= '0;
         cap_cc  <= '0;
         cap_id  <= '0;
         vhi     <= '0;
         vlo     <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st      <= ST_RUN;
                  step    <= '0;
                  cap_pc  <= pc_in;
                  cap_sp  <= sp_in;
                  cap_vec <= start_vec;
                  cap_x   <= x_in;
                  cap_a   <= a_in;
                  cap_cc  <= cc_in;
                  cap_id  <= start_id;
               end
            end
            default: begin
               if (step == LAST_STEP) begin
                  st   <= ST_IDLE;
                  step <= '0;
               end else begin
                  step <= step + SW'(1);
               end
               if (step == VHI_STEP + SW'(1)) vhi <= vec_rdata;
               if (step == VLO_STEP + SW'(1)) vlo <= vec_rdata;
            end
         endcase
      end
   end

   always_comb begin
      busy      = (st == ST_RUN);
      mem_we    = busy && (step <= PUSH_LAST);
      mem_waddr = cap_sp - addr_t'(step);
      case (step)
         SW'(0):  mem_wdata = cap_pc[7:0];
         SW'(1):  mem_wdata = cap_pc[15:8];
         SW'(2):  mem_wdata = cap_x;
         SW'(3):  mem_wdata = cap_a;
         default: mem_wdata = cap_cc;
      endcase
      vec_re       = busy && ((step == VHI_STEP) || (step == VLO_STEP));
      vec_addr     = cap_vec + {{(AW-1){1'b0}}, (step == VLO_STEP)};
      new_pc       = {vhi, vlo};
      new_pc_valid = busy && (step == LAST_STEP);
      new_cc       = cap_cc | MASK_ONE;
      new_sp       = cap_sp - addr_t'(PUSH_BYTES);
      ack          = new_pc_valid;
      ack_src      = cap_id;
   end

   generate
      if (ENTRY_CYCLES < PUSH_BYTES + 4) begin : g_bad_len
         $error("irq_entry_fsm: ENTRY_CYCLES too small for the sequence");
      end
      if (MASK_BIT < 0 || MASK_BIT >= DW) begin : g_bad_mask
         $error("irq_entry_fsm: MASK_BIT outside the byte");
      end
   endgenerate

   // independent run-length counter for the busy window
   logic [7:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n) run_len <= '0;
      else if (busy) run_len <= run_len + 8'd1;
      else run_len <= '0;
   end

   p_entry_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
      new_pc_valid |-> (run_len == 8'(ENTRY_CYCLES - 1)));

   p_release_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      new_pc_valid |=> !busy);

   p_ports_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, vec_re, new_pc_valid}));

   p_push_descends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) - addr_t'(1)));

   p_mask_on_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
      new_pc_valid |-> new_cc[MASK_BIT]);

   p_vec_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_re && $past(vec_re)) |-> (vec_addr == $past(vec_addr) + addr_t'(1)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
   #(parameter int ENTRY_CYCLES = 11,
     parameter int MASK_BIT     = 3,
     parameter bit FULL_SET     = 1'b1)
   (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        nmi_line,
   input  logic [7:0]  irq_lines,
   input  logic        insn_boundary,
   input  logic [15:0] pc_in,
   input  logic [7:0]  x_in,
   input  logic [7:0]  a_in,
   input  logic [7:0]  cc_in,
   input  logic [15:0] sp_in,
   input  logic [7:0]  vec_rdata,
   output logic        busy,
   output logic        mem_we,
   output logic [15:0] mem_waddr,
   output logic [7:0]  mem_wdata,
   output logic        vec_re,
   output logic [15:0] vec_addr,
   output logic [15:0] new_pc,
   output logic        new_pc_valid,
   output logic [7:0]  new_cc,
   output logic [15:0] new_sp,
   output logic        ack,
   output logic [3:0]  ack_src
   );

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] clr;
   logic               grant_valid;
   src_id_t            grant_id;
   addr_t              grant_vec;
   logic               start;

   irq_latch_bank #(.N(NUM_SRC)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .lines ({nmi_line, irq_lines}),
      .clr   (clr),
      .pend  (pend)
   );

   irq_prio_pick #(.FULL_SET(FULL_SET)) u_pick (
      .pend        (pend),
      .mask_set    (cc_in[MASK_BIT]),
      .grant_valid (grant_valid),
      .grant_id    (grant_id),
      .grant_vec   (grant_vec)
   );

   assign start = insn_boundary && !busy && grant_valid;
   assign clr   = start ? (NUM_SRC'(1) << grant_id) : '0;

   irq_entry_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .MASK_BIT(MASK_BIT)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_id     (grant_id),
      .start_vec    (grant_vec),
      .pc_in        (pc_in),
      .x_in         (x_in),
      .a_in         (a_in),
      .cc_in        (cc_in),
      .sp_in        (sp_in),
      .vec_rdata    (vec_rdata),
      .busy         (busy),
      .mem_we       (mem_we),
      .mem_waddr    (mem_waddr),
      .mem_wdata    (mem_wdata),
      .vec_re       (vec_re),
      .vec_addr     (vec_addr),
      .new_pc       (new_pc),
      .new_pc_valid (new_pc_valid),
      .new_cc       (new_cc),
      .new_sp       (new_sp),
      .ack          (ack),
      .ack_src      (ack_src)
   );

   generate
      if (FULL_SET) begin : g_full_chk
         p_nmi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (start && pend[NMI_ID]) |-> (grant_id == src_id_t'(NMI_ID)));
      end else begin : g_single_chk
         p_single_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> (clr == NUM_SRC'(1)));
      end
   endgenerate

   p_mask_respected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (grant_id != src_id_t'(NMI_ID))) |-> !cc_in[MASK_BIT]);

   p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr));

   p_start_on_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_boundary));
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_line = 1'b0;
   logic [7:0]  irq_lines = '0;
   logic        insn_boundary = 1'b0;
   logic [15:0] pc_in = 16'h1234;
   logic [7:0]  x_in = 8'h11, a_in = 8'h22, cc_in = 8'h00;
   logic [15:0] sp_in = 16'h01F0;
   logic [7:0]  vec_rdata = '0, r_vec_rdata = '0;

   logic        busy, mem_we, vec_re, new_pc_valid, ack;
   logic [15:0] mem_waddr, vec_addr, new_pc, new_sp;
   logic [7:0]  mem_wdata, new_cc;
   logic [3:0]  ack_src;
   logic        r_busy, r_mem_we, r_vec_re, r_valid, r_ack;
   logic [15:0] r_mem_waddr, r_vec_addr, r_new_pc, r_new_sp;
   logic [7:0]  r_mem_wdata, r_new_cc;
   logic [3:0]  r_ack_src;

   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   irq_entry_seq i_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .irq_lines(irq_lines),
      .insn_boundary(insn_boundary), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
      .cc_in(cc_in), .sp_in(sp_in), .vec_rdata(vec_rdata), .busy(busy),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .vec_re(vec_re), .vec_addr(vec_addr), .new_pc(new_pc),
      .new_pc_valid(new_pc_valid), .new_cc(new_cc), .new_sp(new_sp),
      .ack(ack), .ack_src(ack_src));

   irq_entry_seq #(.FULL_SET(1'b0)) i_irq_entry_seq_red (
      .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .irq_lines(irq_lines),
      .insn_boundary(insn_boundary), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
      .cc_in(cc_in), .sp_in(sp_in), .vec_rdata(r_vec_rdata), .busy(r_busy),
      .mem_we(r_mem_we), .mem_waddr(r_mem_waddr), .mem_wdata(r_mem_wdata),
      .vec_re(r_vec_re), .vec_addr(r_vec_addr), .new_pc(r_new_pc),
      .new_pc_valid(r_valid), .new_cc(r_new_cc), .new_sp(r_new_sp),
      .ack(r_ack), .ack_src(r_ack_src));

   function automatic logic [7:0] fmem(input logic [15:0] ad);
      return ad[7:0] ^ ad[15:8] ^ 8'hA5;
   endfunction

   always @(posedge clk) begin
      if (vec_re)   vec_rdata   <= fmem(vec_addr);
      if (r_vec_re) r_vec_rdata <= fmem(r_vec_addr);
   end

   // monitor, sampling away from the active edge
   int busy_cnt, nw, n_valid, n_ack, r_n_valid;
   logic [15:0] wa [0:7];
   logic [7:0]  wd [0:7];
   logic [15:0] got_pc, got_sp, r_got_pc;
   logic [7:0]  got_cc;
   logic [3:0]  got_src;

   always @(negedge clk) begin
      if (busy) busy_cnt++;
      if (mem_we) begin
         if (nw < 8) begin wa[nw] = mem_waddr; wd[nw] = mem_wdata; end
         nw++;
      end
      if (new_pc_valid) begin
         n_valid++; got_pc = new_pc; got_sp = new_sp; got_cc = new_cc;
      end
      if (ack) begin n_ack++; got_src = ack_src; end
      if (r_valid) begin r_n_valid++; r_got_pc = r_new_pc; end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      busy_cnt = 0; nw = 0; n_valid = 0; n_ack = 0; r_n_valid = 0;
   endtask

   task automatic pulse(input logic nmi, input logic [7:0] m);
      @(negedge clk); nmi_line = nmi; irq_lines = m;
      @(negedge clk); nmi_line = 1'b0; irq_lines = '0;
   endtask

   // one boundary, optional pulse during the entry, then the checks
   task automatic entry(input bit taken, input int id, input logic [15:0] vec,
                        input int mid_line, input string req);
      @(negedge clk);
      clear_mon();
      insn_boundary = 1'b1;
      @(negedge clk);
      insn_boundary = 1'b0;
      if (mid_line >= 0) begin
         repeat (2) @(negedge clk);
         irq_lines[mid_line] = 1'b1;
         @(negedge clk);
         irq_lines = '0;
      end
      repeat (14) @(negedge clk);
      if (!taken) begin
         check({req, " no entry busy"}, busy_cnt, 0);
         check({req, " no entry strobe"}, n_valid, 0);
      end else begin
         check({req, " R8 busy length"}, busy_cnt, 11);
         check({req, " R9 one strobe"}, n_valid, 1);
         check({req, " R9 one ack"}, n_ack, 1);
         check({req, " R9 ack source"}, got_src, id);
         check({req, " R9 new pc"}, got_pc, {fmem(vec), fmem(vec + 16'd1)});
         check({req, " R6 mask set"}, got_cc, cc_in | 8'h08);
         check({req, " R5 new sp"}, got_sp, sp_in - 16'd5);
         check({req, " R5 write count"}, nw, 5);
         for (int k = 0; k < 5; k++)
            check({req, " R5 write addr"}, wa[k], sp_in - 16'(k));
         check({req, " R5 pc low"}, wd[0], pc_in[7:0]);
         check({req, " R5 pc high"}, wd[1], pc_in[15:8]);
         check({req, " R5 x"}, wd[2], x_in);
         check({req, " R5 a"}, wd[3], a_in);
         check({req, " R5 cc"}, wd[4], cc_in);
      end
   endtask

   function automatic logic [15:0] vbase(input int id);
      case (id)
         0: return 16'h1FF8; 1: return 16'h1FEC; 2: return 16'h1FEA;
         3: return 16'h1FF6; 4: return 16'h1FF4; 5: return 16'h1FF2;
         6: return 16'h1FF0; 7: return 16'h1FEE; default: return 16'h1FFC;
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 reset busy", busy, 0);
      check("R10 reset ack", ack, 0);
      check("R10 reset write", mem_we, 0);

      // R10 reset clears latches
      pulse(1'b0, 8'h08);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      entry(0, 0, 0, -1, "R10 reset clear");

      // R1 R4 each maskable source alone, line already low at boundary
      for (int k = 0; k < 8; k++) begin
         pc_in = 16'h4000 + 16'(k) * 16'h0111;
         x_in = 8'(k) + 8'h30; a_in = 8'(k) ^ 8'hC3;
         pulse(1'b0, 8'(1) << k);
         repeat (2) @(negedge clk);
         entry(1, k, vbase(k), -1, "R1 R4 single");
      end

      // R2 non-maskable with mask set
      cc_in = 8'h08;
      pulse(1'b1, 8'h00);
      entry(1, 8, 16'h1FFC, -1, "R2 nmi masked");

      // R3 blocked while masked, then taken
      pulse(1'b0, 8'h04);
      entry(0, 0, 0, -1, "R3 masked");
      cc_in = 8'h00;
      entry(1, 2, vbase(2), -1, "R3 unmasked");

      // R4 R7 every pair drains in order
      for (int i = 0; i < 8; i++) begin
         for (int j = i + 1; j < 8; j++) begin
            pulse(1'b0, (8'(1) << i) | (8'(1) << j));
            entry(1, i, vbase(i), -1, "R4 R7 pair first");
            entry(1, j, vbase(j), -1, "R4 R7 pair second");
         end
      end

      // R2 R7 nmi ahead of each maskable
      for (int k = 0; k < 8; k++) begin
         pulse(1'b1, 8'(1) << k);
         entry(1, 8, 16'h1FFC, -1, "R2 R7 nmi first");
         entry(1, k, vbase(k), -1, "R2 R7 maskable after");
      end

      // R10 request during an entry
      pulse(1'b0, 8'h01);
      entry(1, 0, vbase(0), 4, "R10 in-flight");
      entry(1, 4, vbase(4), -1, "R10 latched during entry");

      // R8 no boundary, no entry
      pulse(1'b0, 8'h02);
      clear_mon();
      repeat (20) @(negedge clk);
      check("R8 no boundary busy", busy_cnt, 0);
      entry(1, 1, vbase(1), -1, "R8 with boundary");

      // R11 reduced build
      pulse(1'b0, 8'h01);
      entry(1, 0, vbase(0), -1, "R11 full side");
      check("R11 reduced strobe", r_n_valid, 1);
      check("R11 reduced vector", r_got_pc, {fmem(16'hFFFA), fmem(16'hFFFB)});
      pulse(1'b1, 8'h00);
      entry(1, 8, 16'h1FFC, -1, "R11 nmi on full");
      check("R11 reduced ignores nmi", r_n_valid, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule